// File: doc/BRIEF.md
# Interrupt Enable and Pending Controller

This block keeps the per-line state of an interrupt controller for up to 256 request lines: an enable bit, a pending bit, an active bit and a priority for every line. Software reaches all of it through a 32-bit register port with word addressing and byte-lane enables. Enable and pending state each have two write views. In one, a 1 bit sets the state. In the other, a 1 bit clears it. Zero bits never change anything, so software needs no read-modify-write.

A rising edge on a request input makes that line pending. The block offers the most urgent line that is both pending and enabled on a valid/ready winner port. A lower priority value is more urgent, and among equal values the lower line number wins. Taking the offer (valid and ready high together) moves that line from pending to active. A separate end-of-interrupt input names a line whose active bit is to be cleared. The winner offer is a status view of the current state, not a queued transfer. `win_valid` may drop and `win_id` may change without a handshake whenever enables, pendings or priorities change. The consumer samples the offer in the same cycle it raises `win_ready`.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset every enable, pending and active bit and every priority is zero, `win_valid` is low and `bus_rvalid` is low.
- R2: A write to word address 0x00+k sets enable for line 32k+b for each 1 in data bit b of an enabled byte lane; 0 bits and disabled lanes have no effect. A read of 0x00+k or 0x20+k returns the enable bits of lines 32k..32k+31.
- R3: A write to word address 0x20+k clears enable for each line whose data bit is 1 in an enabled lane, leaving the others.
- R4: A write to 0x40+k sets and a write to 0x60+k clears pending bits with the same write-one rule; reading either address returns the pending bits.
- R5: A 0-to-1 change on `irq_in[n]` sets pending for line n whether or not the line is enabled; a level held high does not set it again after software clears it.
- R6: Word address 0xC0+j holds the priorities of lines 4j..4j+3, line 4j+i in byte lane i. A write keeps data bits 7:5 of each enabled lane. A read returns those 3 bits in bits 7:5 of each lane with bits 4:0 as zero.
- R7: `win_valid` is high exactly when some line is both pending and enabled. `win_id` is the such line with the lowest priority value, the lowest line number among equals. `win_prio` is its priority.
- R8: When `win_valid` and `win_ready` are both high, in the next cycle the offered line is active and no longer pending, unless a new set arrives for it in that cycle.
- R9: `eoi_valid` with `eoi_id` = n clears the active bit of line n in the next cycle.
- R10: Word address 0x80+k reads the active bits of lines 32k..32k+31; writes there change nothing.
- R11: `bus_rvalid` rises exactly one cycle after a read request, with `bus_rdata` holding the state before that cycle's updates. Byte enables are ignored on reads. Words 0xA0..0xBF and word indices at or above N_LINES/32 read zero and ignore writes.
- R12: An edge or a software set in the same cycle as a software clear or an acknowledge of the same line leaves it pending. An acknowledge and an end-of-interrupt of the same line in one cycle leave it active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Request lines, synchronous to clk, rising edge sets pending |
| bus_req | input | 1 | Register access request, one access per cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Word address |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| win_valid | output | 1 | A pending and enabled line is offered |
| win_ready | input | 1 | Acknowledge of the offered line |
| win_id | output | log2(N_LINES) | Offered line number |
| win_prio | output | PRIO_BITS | Priority of the offered line |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | log2(N_LINES) | Line whose active bit is cleared |

## Verification
The assertions assume that request inputs are already synchronous to the clock. They also assume that an end-of-interrupt is never issued in the same cycle as an acknowledge of that same line; the end-of-interrupt check exempts that pairing explicitly. Line numbers always fall inside the line range, because N_LINES is a power of two. The stimulus raises `win_ready` only as a random sample of the current offer, without holding it. It draws end-of-interrupt numbers at random, including lines that are not active, and it spreads register accesses over every view, including unmapped words. The directed cases exercise byte lanes, ties, and set-versus-clear collisions.

// File: rtl/ipc_pkg.sv
`timescale 1ns/1ps
package ipc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 8;

  // Register view selected by the upper word-address bits
  typedef enum logic [2:0] {
    CLS_SETEN = 3'd0,
    CLS_CLREN = 3'd1,
    CLS_SETPD = 3'd2,
    CLS_CLRPD = 3'd3,
    CLS_ACT   = 3'd4,
    CLS_NONE  = 3'd5,
    CLS_PRIO  = 3'd6
  } reg_cls_e;

  function automatic reg_cls_e decode_cls(input logic [ADDR_W-1:0] a);
    if (a[7:6] == 2'b11) return CLS_PRIO;
    case (a[7:5])
      3'd0:    return CLS_SETEN;
      3'd1:    return CLS_CLREN;
      3'd2:    return CLS_SETPD;
      3'd3:    return CLS_CLRPD;
      3'd4:    return CLS_ACT;
      default: return CLS_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/ipc_edge_det.sv
`timescale 1ns/1ps
module ipc_edge_det #(
  parameter int unsigned WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/ipc_bus_decode.sv
`timescale 1ns/1ps
module ipc_bus_decode
  import ipc_pkg::*;
#(
  parameter int unsigned N_LINES = 256
) (
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [3:0]          bus_be,
  input  logic [WORD_W-1:0]   bus_wdata,
  output reg_cls_e            cls_o,
  output logic [4:0]          st_widx_o,
  output logic [5:0]          prio_widx_o,
  output logic                prio_we_o,
  output logic [N_LINES-1:0]  set_en_o,
  output logic [N_LINES-1:0]  clr_en_o,
  output logic [N_LINES-1:0]  set_pd_o,
  output logic [N_LINES-1:0]  clr_pd_o
);
  localparam int unsigned NW = N_LINES / WORD_W;

  logic                wr;
  logic [WORD_W-1:0]   wmask;
  logic [N_LINES-1:0]  spread;

  assign cls_o       = decode_cls(bus_addr);
  assign st_widx_o   = bus_addr[4:0];
  assign prio_widx_o = bus_addr[5:0];
  assign wr          = bus_req & bus_we;
  assign wmask       = bus_wdata & lane_mask(bus_be);

  // Place the masked write data at the addressed state word
  for (genvar w = 0; w < NW; w++) begin : g_word
    assign spread[w*WORD_W +: WORD_W] = (st_widx_o == 5'(w)) ? wmask : '0;
  end

  assign set_en_o  = (wr && cls_o == CLS_SETEN) ? spread : '0;
  assign clr_en_o  = (wr && cls_o == CLS_CLREN) ? spread : '0;
  assign set_pd_o  = (wr && cls_o == CLS_SETPD) ? spread : '0;
  assign clr_pd_o  = (wr && cls_o == CLS_CLRPD) ? spread : '0;
  assign prio_we_o = wr && cls_o == CLS_PRIO;
endmodule

// File: rtl/ipc_prio_bank.sv
`timescale 1ns/1ps
module ipc_prio_bank
  import ipc_pkg::*;
#(
  parameter int unsigned N_LINES = 256,
  parameter int unsigned PW      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [5:0]              widx_i,
  input  logic [3:0]              be_i,
  input  logic [4*PW-1:0]         fields_i,
  output logic [WORD_W-1:0]       rd_word_o,
  output logic [N_LINES*PW-1:0]   prio_flat_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  logic [PW-1:0] prio_q [N_LINES];

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    localparam int unsigned LANE = n % 4;
    localparam int unsigned WI   = n / 4;
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_q[n] <= '0;
      else if (we_i && widx_i == 6'(WI) && be_i[LANE])
        prio_q[n] <= fields_i[LANE*PW +: PW];
    end
    assign prio_flat_o[n*PW +: PW] = prio_q[n];
  end

  // Kept bits return in the top of each byte, the rest read zero
  always_comb begin
    logic [7:0] line8;
    line8     = '0;
    rd_word_o = '0;
    for (int l = 0; l < 4; l++) begin
      line8 = {widx_i, 2'(l)};
      if (32'(line8) < N_LINES)
        rd_word_o[8*l+7 -: PW] = prio_q[line8[IW-1:0]];
    end
  end
endmodule

// File: rtl/ipc_winner_tree.sv
`timescale 1ns/1ps
module ipc_winner_tree #(
  parameter int unsigned N_LINES = 256,
  parameter int unsigned PW      = 3,
  localparam int unsigned IW     = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]    cand_i,
  input  logic [N_LINES*PW-1:0] prio_i,
  output logic                  any_o,
  output logic [IW-1:0]         id_o,
  output logic [PW-1:0]         prio_o
);
  // Heap layout: leaves at N_LINES..2*N_LINES-1, root at 1
  logic          hv [1:2*N_LINES-1];
  logic [PW-1:0] hp [1:2*N_LINES-1];
  logic [IW-1:0] hi [1:2*N_LINES-1];

  for (genvar n = 0; n < N_LINES; n++) begin : g_leaf
    assign hv[N_LINES+n] = cand_i[n];
    assign hp[N_LINES+n] = prio_i[n*PW +: PW];
    assign hi[N_LINES+n] = IW'(n);
  end

  // Left child holds lower line numbers, so right wins only when strictly more urgent
  for (genvar k = 1; k < N_LINES; k++) begin : g_node
    logic pick_r;
    assign pick_r = hv[2*k+1] && (!hv[2*k] || (hp[2*k+1] < hp[2*k]));
    assign hv[k]  = hv[2*k] | hv[2*k+1];
    assign hp[k]  = pick_r ? hp[2*k+1] : hp[2*k];
    assign hi[k]  = pick_r ? hi[2*k+1] : hi[2*k];
  end

  assign any_o  = hv[1];
  assign id_o   = hi[1];
  assign prio_o = hp[1];
endmodule

// File: rtl/irq_pend_ctrl.sv
`timescale 1ns/1ps
module irq_pend_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned N_LINES   = 256,
  parameter int unsigned PRIO_BITS = 3,
  localparam int unsigned IW       = $clog2(N_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   irq_in,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic                 bus_rvalid,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 win_valid,
  input  logic                 win_ready,
  output logic [IW-1:0]        win_id,
  output logic [PRIO_BITS-1:0] win_prio,
  input  logic                 eoi_valid,
  input  logic [IW-1:0]        eoi_id
);
  localparam int unsigned NW = N_LINES / WORD_W;

  logic [N_LINES-1:0] en_q, pd_q, act_q;
  logic [N_LINES-1:0] rise_v, cand_v, ack_v, eoi_v;
  logic [N_LINES-1:0] set_en_v, clr_en_v, set_pd_v, clr_pd_v;
  reg_cls_e           cls;
  logic [4:0]         st_widx;
  logic [5:0]         prio_widx;
  logic               prio_we;
  logic [4*PRIO_BITS-1:0]     prio_fields;
  logic [WORD_W-1:0]          prio_rd_word, state_word, rd_word;
  logic [N_LINES*PRIO_BITS-1:0] prio_flat;
  logic               fire;
  logic               rvalid_q;
  logic [WORD_W-1:0]  rdata_q;

  ipc_edge_det #(.WIDTH(N_LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (irq_in),
    .rise_o (rise_v)
  );

  ipc_bus_decode #(.N_LINES(N_LINES)) u_dec (
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .cls_o       (cls),
    .st_widx_o   (st_widx),
    .prio_widx_o (prio_widx),
    .prio_we_o   (prio_we),
    .set_en_o    (set_en_v),
    .clr_en_o    (clr_en_v),
    .set_pd_o    (set_pd_v),
    .clr_pd_o    (clr_pd_v)
  );

  // Top bits of each byte lane are the only priority bits stored
  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign prio_fields[l*PRIO_BITS +: PRIO_BITS] = bus_wdata[8*l+7 -: PRIO_BITS];
  end

  ipc_prio_bank #(.N_LINES(N_LINES), .PW(PRIO_BITS)) u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (prio_we),
    .widx_i      (prio_widx),
    .be_i        (bus_be),
    .fields_i    (prio_fields),
    .rd_word_o   (prio_rd_word),
    .prio_flat_o (prio_flat)
  );

  assign cand_v = pd_q & en_q;

  ipc_winner_tree #(.N_LINES(N_LINES), .PW(PRIO_BITS)) u_win (
    .cand_i (cand_v),
    .prio_i (prio_flat),
    .any_o  (win_valid),
    .id_o   (win_id),
    .prio_o (win_prio)
  );

  assign fire  = win_valid & win_ready;
  assign ack_v = fire      ? ({{(N_LINES-1){1'b0}}, 1'b1} << win_id) : '0;
  assign eoi_v = eoi_valid ? ({{(N_LINES-1){1'b0}}, 1'b1} << eoi_id) : '0;

  // Sets are applied after clears so a same-cycle event is never lost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pd_q  <= '0;
      act_q <= '0;
    end else begin
      en_q  <= (en_q | set_en_v) & ~clr_en_v;
      pd_q  <= (pd_q & ~clr_pd_v & ~ack_v) | rise_v | set_pd_v;
      act_q <= (act_q & ~eoi_v) | ack_v;
    end
  end

  always_comb begin
    state_word = '0;
    for (int w = 0; w < NW; w++) begin
      if (st_widx == 5'(w)) begin
        case (cls)
          CLS_SETEN, CLS_CLREN: state_word = en_q[w*WORD_W +: WORD_W];
          CLS_SETPD, CLS_CLRPD: state_word = pd_q[w*WORD_W +: WORD_W];
          CLS_ACT:              state_word = act_q[w*WORD_W +: WORD_W];
          default:              state_word = '0;
        endcase
      end
    end
    rd_word = (cls == CLS_PRIO) ? prio_rd_word : state_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_req & ~bus_we;
      if (bus_req && !bus_we) rdata_q <= rd_word;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/ipc_checker.sv
`timescale 1ns/1ps
module ipc_checker #(
  parameter int unsigned N_LINES = 256,
  localparam int unsigned IW     = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_in,
  input logic               bus_req,
  input logic               bus_we,
  input logic [2:0]         addr_hi,
  input logic               bus_rvalid,
  input logic [31:0]        bus_rdata,
  input logic               win_valid,
  input logic               win_ready,
  input logic [IW-1:0]      win_id,
  input logic               eoi_valid,
  input logic [IW-1:0]      eoi_id,
  input logic [N_LINES-1:0] en_q,
  input logic [N_LINES-1:0] pd_q,
  input logic [N_LINES-1:0] act_q
);
  logic [N_LINES-1:0] irq_d, rise;
  logic rd_req, fire;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_d <= '0;
    else        irq_d <= irq_in;
  end

  assign rise   = irq_in & ~irq_d;
  assign rd_req = bus_req & ~bus_we;
  assign fire   = win_valid & win_ready;

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  p_prio_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && addr_hi[2:1] == 2'b11) |=> ((bus_rdata & 32'h1F1F_1F1F) == 32'h0));

  p_win_cand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pd_q[win_id] && en_q[win_id]));

  p_win_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_q & en_q) == '0) |-> !win_valid);

  p_ack_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> act_q[$past(win_id)]);

  p_eoi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !(fire && win_id == eoi_id)) |=> !act_q[$past(eoi_id)]);

  p_active_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && addr_hi == 3'b100 && !fire && !eoi_valid) |=> (act_q == $past(act_q)));

  p_edge_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pd_q & $past(rise)) == $past(rise)));
endmodule

bind irq_pend_ctrl ipc_checker #(.N_LINES(N_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .addr_hi    (bus_addr[7:5]),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata),
  .win_valid  (win_valid),
  .win_ready  (win_ready),
  .win_id     (win_id),
  .eoi_valid  (eoi_valid),
  .eoi_id     (eoi_id),
  .en_q       (en_q),
  .pd_q       (pd_q),
  .act_q      (act_q)
);

// File: tb/irq_pend_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb;
  localparam int N = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic          win_valid;
  logic          win_ready = 1'b0;
  logic [7:0]    win_id;
  logic [2:0]    win_prio;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_id = '0;

  always #4 clk = ~clk;

  irq_pend_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .win_valid(win_valid), .win_ready(win_ready), .win_id(win_id), .win_prio(win_prio),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_en = '0, m_pd = '0, m_act = '0, m_prev = '0;
  logic [2:0]   m_pr [N];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mwin();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pd[i] && (b < 0 || m_pr[i] < m_pr[b])) b = i;
    return b;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] r = '0;
    int w = int'(a[4:0]);
    if (a[7:6] == 2'b11) begin
      for (int l = 0; l < 4; l++) r[8*l+7 -: 3] = m_pr[{a[5:0], 2'(l)}];
    end else if (w < N/32) begin
      case (a[7:5])
        3'd0, 3'd1: r = m_en[w*32 +: 32];
        3'd2, 3'd3: r = m_pd[w*32 +: 32];
        3'd4:       r = m_act[w*32 +: 32];
        default:    r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [N-1:0] spread(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [N-1:0] v = '0;
    int w = int'(a[4:0]);
    if (w < N/32) v[w*32 +: 32] = d & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return v;
  endfunction

  task automatic chk_win();
    int w = mwin();
    chk(win_valid == (w >= 0), "R7 valid", {31'b0, win_valid}, {31'b0, (w >= 0)});
    if (w >= 0 && win_valid)
      chk({win_prio, win_id} == {m_pr[w], 8'(w)}, "R7 winner",
          {21'b0, win_prio, win_id}, {21'b0, m_pr[w], 8'(w)});
  endtask

  // One clock: model next state from current inputs, then compare after the edge
  task automatic tick(input string tag);
    bit           rd   = bus_req && !bus_we;
    bit           wr   = bus_req && bus_we;
    logic [31:0]  exp  = mread(bus_addr);
    logic [N-1:0] sp   = spread(bus_addr, bus_be, bus_wdata);
    logic [N-1:0] ackv = '0, eoiv = '0, rise, n_en, n_pd, n_act;
    logic [2:0]   cls  = bus_addr[7:5];
    int           w    = mwin();
    if (win_ready && w >= 0) ackv[w] = 1'b1;
    if (eoi_valid) eoiv[eoi_id] = 1'b1;
    rise = irq_in & ~m_prev;
    n_en = m_en;
    if (wr && cls == 3'd0) n_en = m_en | sp;
    if (wr && cls == 3'd1) n_en = m_en & ~sp;
    n_pd = m_pd & ~ackv;
    if (wr && cls == 3'd3) n_pd = n_pd & ~sp;
    n_pd = n_pd | rise;
    if (wr && cls == 3'd2) n_pd = n_pd | sp;
    n_act = (m_act & ~eoiv) | ackv;
    @(posedge clk);
    #2;
    if (wr && bus_addr[7:6] == 2'b11)
      for (int l = 0; l < 4; l++)
        if (bus_be[l]) m_pr[{bus_addr[5:0], 2'(l)}] = bus_wdata[8*l+7 -: 3];
    m_en = n_en; m_pd = n_pd; m_act = n_act; m_prev = irq_in;
    if (rd) chk(bus_rvalid && bus_rdata == exp, tag, bus_rdata, exp);
    chk_win();
  endtask

  task automatic idle();
    bus_req = 1'b0; bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic bwr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    tick("R11");
    idle();
  endtask

  task automatic brd(input logic [7:0] a, input string tag, input logic [31:0] exp);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
    tick(tag);
    idle();
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_pr[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    chk(!win_valid, "R1 win_valid", {31'b0, win_valid}, 32'h0);
    chk(!bus_rvalid, "R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    for (int w = 0; w < 8; w++) begin
      brd(8'(w), "R1", 32'h0);
      brd(8'(8'h40 + w), "R1", 32'h0);
      brd(8'(8'h80 + w), "R1", 32'h0);
    end
    brd(8'hC0, "R1", 32'h0);
    brd(8'hFF, "R1", 32'h0);

    // R2: set-enable, both views read enable state, zero bits and lanes
    bwr(8'h00, 4'hF, 32'h0000_00F1);
    brd(8'h00, "R2", 32'h0000_00F1);
    brd(8'h20, "R2", 32'h0000_00F1);
    bwr(8'h00, 4'hF, 32'h0);
    brd(8'h00, "R2", 32'h0000_00F1);
    bwr(8'h01, 4'b0010, 32'hFFFF_FFFF);
    brd(8'h01, "R2", 32'h0000_FF00);

    // R3: clear-enable
    bwr(8'h20, 4'hF, 32'h0000_0011);
    brd(8'h00, "R3", 32'h0000_00E0);

    // R4: set and clear pending, line disabled stays pending
    bwr(8'h40, 4'hF, 32'h0000_0003);
    brd(8'h40, "R4", 32'h0000_0003);
    chk(!win_valid, "R7 none enabled", {31'b0, win_valid}, 32'h0);
    bwr(8'h60, 4'hF, 32'h0000_0001);
    brd(8'h60, "R4", 32'h0000_0002);

    // R6: priority bytes, low bits dropped, lane enables
    bwr(8'hC1, 4'hF, 32'h1FFF_5F00);
    brd(8'hC1, "R6", 32'h00E0_4000);
    bwr(8'hC1, 4'b0100, 32'hAAAA_AAAA);
    brd(8'hC1, "R6", 32'h00A0_4000);

    // R7: most urgent line, then tie on equal priority
    bwr(8'h40, 4'hF, 32'h0000_00E0);
    chk(win_valid && win_id == 8'd7, "R7 urgent", {24'b0, win_id}, 32'd7);
    bwr(8'hC1, 4'b1000, 32'h4000_0000);
    chk(win_valid && win_id == 8'd5, "R7 tie", {24'b0, win_id}, 32'd5);

    // R8: acknowledge moves line 5 to active
    win_ready = 1'b1;
    tick("R8");
    win_ready = 1'b0;
    brd(8'h80, "R8", 32'h0000_0020);
    brd(8'h40, "R8", 32'h0000_00C2);
    chk(win_valid && win_id == 8'd7, "R7 next", {24'b0, win_id}, 32'd7);

    // R10: active view ignores writes
    bwr(8'h80, 4'hF, 32'hFFFF_FFFF);
    brd(8'h80, "R10", 32'h0000_0020);

    // R9: end of interrupt
    eoi_valid = 1'b1; eoi_id = 8'd5;
    tick("R9");
    eoi_valid = 1'b0;
    brd(8'h80, "R9", 32'h0);

    // R5: edge sets pending on a disabled line, held level does not re-set
    irq_in[100] = 1'b1;
    tick("R5");
    brd(8'h43, "R5", 32'h0000_0010);
    bwr(8'h63, 4'hF, 32'h0000_0010);
    brd(8'h43, "R5", 32'h0);

    // R12: edge in the same cycle as a software clear keeps pending
    irq_in[100] = 1'b0;
    tick("R12");
    irq_in[100] = 1'b1;
    bwr(8'h63, 4'hF, 32'h0000_0010);
    brd(8'h43, "R12", 32'h0000_0010);

    // R11: unmapped words
    bwr(8'hA0, 4'hF, 32'hFFFF_FFFF);
    brd(8'hA0, "R11", 32'h0);
    bwr(8'h08, 4'hF, 32'hFFFF_FFFF);
    brd(8'h08, "R11", 32'h0);

    // Random mix across every view
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom % 8);
      if ($urandom % 4 == 0) irq_in[$urandom % N] ^= 1'b1;
      if ($urandom % 3 != 0) begin
        bus_req   = 1'b1;
        bus_we    = 1'($urandom % 2);
        bus_be    = 4'($urandom);
        bus_wdata = $urandom & $urandom;
        if (sel < 6) bus_addr = {3'(sel), 5'($urandom % 10)};
        else         bus_addr = {2'b11, 6'($urandom % 64)};
      end else begin
        idle();
      end
      win_ready = ($urandom % 3 == 0);
      eoi_valid = ($urandom % 4 == 0);
      eoi_id    = 8'($urandom);
      tick("R11");
    end
    idle();
    win_ready = 1'b0;
    eoi_valid = 1'b0;
    tick("R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule